// File: doc/BRIEF.md
# Timer Event Status Register

This block holds the sticky status of a timer that has two capture/compare channels. It latches per-channel event flags and overrun flags. It also keeps a reload time-out flag, raised by its own 16-bit up-counter, and a noise flag, raised by strobes from an input filter. Software reads all of the flags as one 8-bit byte.

Software clears flags by writing ones to the same byte. An interrupt request goes out while any channel event or the reload time-out is pending and interrupts are enabled.

The counter starts from 0x0001 and advances on every cycle in which `run` is high. When it matches the programmed reload value, it returns to 0x0001 and the reload time-out flag is set. Status byte layout: bit 7 noise, bit 6 reserved, bit 5 overrun channel 1, bit 4 overrun channel 0, bit 3 reload time-out, bit 2 reserved, bit 1 event channel 1, bit 0 event channel 0.

Top module: `tmr_event_status`

## Requirements
- R1: After reset the status byte reads 0x00, the counter reads 0x0001 and `irq` is low.
- R2: Bits 6 and 2 always read 0. Writes to bits 6, 5, 4 and 2 change no flag.
- R3: A pulse on `ch_evt[n]` sets status bit n (bit 0 for channel 0, bit 1 for channel 1) at the next clock edge, whatever the value of `irq_en`.
- R4: A write with bit n (n = 0 or 1) at 1 clears event flag n, and it clears overrun bit 4+n in the same cycle. A write with a bit at 0 leaves that flag unchanged.
- R5: An event on channel n while event flag n is already 1 sets overrun bit 4+n.
- R6: When an event and a clear hit the same event flag in one cycle, the flag ends at 1. The overrun bit is set only if the event flag was 1 before that cycle.
- R7: While `run` is high the counter increments by one each cycle. In a cycle where it equals `reload`, it loads 0x0001 and sets bit 3. Writing 1 to bit 3 clears it.
- R8: Bit 7 is set at the clock edge where `nf_enable` and `nf_strobe` are both high. A strobe while `nf_enable` is low has no effect. Writing 1 to bit 7 clears it.
- R9: `irq` equals `irq_en` AND (bit 0 OR bit 1 OR bit 3). It stays high until software clears those flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Counter advance enable |
| reload | input | 16 | Reload (terminal) count |
| ch_evt | input | 2 | Per-channel capture/compare event pulses |
| nf_enable | input | 1 | Input noise filter enabled |
| nf_strobe | input | 1 | Filter saw centre samples disagreeing with the average |
| irq_en | input | 1 | Interrupt enable |
| wr_en | input | 1 | Status write strobe |
| wr_data | input | 8 | Write data, ones clear flags |
| rd_data | output | 8 | Status byte |
| cnt_value | output | 16 | Current counter value |
| irq | output | 1 | Interrupt request |

## Verification
Every flag, and the counter, responds at the first clock edge after the stimulus is sampled. The status byte is driven combinationally from those registers, so a result is due one cycle after the input. `irq` also follows `irq_en` inside the same cycle.

Inputs change shortly after the falling edge. The bench compares against its model at the next falling edge, which sits exactly one register stage past the stimulus. Directed checks use the same point in time, so each expected value is aimed at the first cycle in which the design may show it.

// File: rtl/tmr_stat_pkg.sv
package tmr_stat_pkg;
   localparam int STAT_W = 8;
   localparam int NUM_CH = 2;

   typedef struct packed {
      logic             noise;
      logic             rsv_hi;
      logic [NUM_CH-1:0] ovr;
      logic             rto;
      logic             rsv_lo;
      logic [NUM_CH-1:0] evt;
   } stat_t;

   localparam int POS_EVT   = 0;
   localparam int POS_RTO   = 3;
   localparam int POS_OVR   = 4;
   localparam int POS_NOISE = 7;
endpackage

// File: rtl/tmr_reload_cnt.sv
module tmr_reload_cnt #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] reload,
   output logic [CNT_W-1:0] count,
   output logic             wrap
);
   localparam logic [CNT_W-1:0] RESTART = CNT_W'(1);

   initial begin
      if (CNT_W < 2) $error("tmr_reload_cnt: CNT_W must be at least 2");
   end

   assign wrap = run && (count == reload);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      count <= RESTART;
      else if (wrap)   count <= RESTART;
      else if (run)    count <= count + 1'b1;
   end
endmodule

// File: rtl/tmr_chan_flag.sv
module tmr_chan_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   input  logic clr,
   output logic ef,
   output logic ov
);
   logic ef_nxt, ov_nxt;

   always_comb begin
      ef_nxt = evt | (ef & ~clr);
      ov_nxt = (evt & ef) | (ov & ~clr);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ef <= 1'b0;
         ov <= 1'b0;
      end else begin
         ef <= ef_nxt;
         ov <= ov_nxt;
      end
   end
endmodule

// File: rtl/tmr_sticky_flag.sv
module tmr_sticky_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= 1'b0;
      else if (set)  q <= 1'b1;
      else if (clr)  q <= 1'b0;
   end
endmodule

// File: rtl/tmr_event_status.sv
module tmr_event_status
   import tmr_stat_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int CH_N  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] reload,
   input  logic [CH_N-1:0]  ch_evt,
   input  logic             nf_enable,
   input  logic             nf_strobe,
   input  logic             irq_en,
   input  logic             wr_en,
   input  logic [7:0]       wr_data,
   output logic [7:0]       rd_data,
   output logic [CNT_W-1:0] cnt_value,
   output logic             irq
);
   initial begin
      if (CH_N != NUM_CH) $error("tmr_event_status: status layout fixes CH_N at 2");
      if (CNT_W < 2)      $error("tmr_event_status: CNT_W too small");
   end

   stat_t            stat;
   logic [CH_N-1:0]  ef, ov;
   logic             rto_q, noise_q, wrap;
   logic [7:0]       clr_mask;
   logic             wr_unused;

   assign clr_mask  = wr_en ? wr_data : 8'h00;
   assign wr_unused = ^{wr_data[6:4], wr_data[2]};

   tmr_reload_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .reload (reload),
      .count  (cnt_value),
      .wrap   (wrap)
   );

   for (genvar g = 0; g < CH_N; g++) begin : g_ch
      tmr_chan_flag u_flag (
         .clk   (clk),
         .rst_n (rst_n),
         .evt   (ch_evt[g]),
         .clr   (clr_mask[POS_EVT+g]),
         .ef    (ef[g]),
         .ov    (ov[g])
      );
   end

   tmr_sticky_flag u_rto (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (wrap),
      .clr   (clr_mask[POS_RTO]),
      .q     (rto_q)
   );

   tmr_sticky_flag u_noise (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (nf_enable & nf_strobe),
      .clr   (clr_mask[POS_NOISE]),
      .q     (noise_q)
   );

   always_comb begin
      stat        = '0;
      stat.evt    = ef;
      stat.ovr    = ov;
      stat.rto    = rto_q;
      stat.noise  = noise_q;
      stat.rsv_hi = 1'b0;
      stat.rsv_lo = 1'b0;
   end

   assign rd_data = stat;
   assign irq     = irq_en & ((|ef) | rto_q);
endmodule

// File: rtl/tmr_event_status_chk.sv
module tmr_event_status_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic [CNT_W-1:0] reload,
   input logic [1:0]       ch_evt,
   input logic             nf_enable,
   input logic             nf_strobe,
   input logic             irq_en,
   input logic [7:0]       rd_data,
   input logic [CNT_W-1:0] cnt_value,
   input logic             irq
);
   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[6] == 1'b0) && (rd_data[2] == 1'b0)); // R2

   AST_EVT0_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      ch_evt[0] |=> rd_data[0]); // R3

   AST_EVT1_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      ch_evt[1] |=> rd_data[1]); // R3

   AST_OVR_IMPLIES_EVT: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[5:4] & ~rd_data[1:0]) == 2'b00); // R4

   AST_OVR0_ON_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_evt[0] && rd_data[0]) |=> rd_data[4]); // R5

   AST_OVR1_ON_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_evt[1] && rd_data[1]) |=> rd_data[5]); // R5

   AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (run && cnt_value == reload) |=> (cnt_value == CNT_W'(1)) && rd_data[3]); // R7

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (run && cnt_value != reload) |=> cnt_value == ($past(cnt_value) + 1'b1)); // R7

   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(cnt_value)); // R7

   AST_NOISE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !(nf_enable && nf_strobe) |=> !$rose(rd_data[7])); // R8

   AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> irq_en); // R9

   AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (rd_data[0] || rd_data[1] || rd_data[3])); // R9
endmodule

bind tmr_event_status tmr_event_status_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .run       (run),
   .reload    (reload),
   .ch_evt    (ch_evt),
   .nf_enable (nf_enable),
   .nf_strobe (nf_strobe),
   .irq_en    (irq_en),
   .rd_data   (rd_data),
   .cnt_value (cnt_value),
   .irq       (irq)
);

// File: tb/tb_tmr_event_status.sv
module tb_tmr_event_status;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run = 1'b0;
   logic [15:0] reload = 16'd5;
   logic [1:0]  ch_evt = 2'b00;
   logic        nf_enable = 1'b0;
   logic        nf_strobe = 1'b0;
   logic        irq_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_data = 8'h00;
   logic [7:0]  rd_data;
   logic [15:0] cnt_value;
   logic        irq;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tmr_event_status dut (
      .clk(clk), .rst_n(rst_n), .run(run), .reload(reload), .ch_evt(ch_evt),
      .nf_enable(nf_enable), .nf_strobe(nf_strobe), .irq_en(irq_en),
      .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .cnt_value(cnt_value), .irq(irq)
   );

   // behavioural reference model
   bit m_ef[2], m_ov[2], m_rto, m_noise;
   int m_cnt = 1;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ef = '{0, 0}; m_ov = '{0, 0}; m_rto = 0; m_noise = 0; m_cnt = 1;
      end else begin
         for (int c = 0; c < 2; c++) begin
            bit clr, was;
            clr = wr_en && wr_data[c];
            was = m_ef[c];
            if (clr) begin m_ef[c] = 0; m_ov[c] = 0; end
            if (ch_evt[c]) begin
               m_ef[c] = 1;
               if (was) m_ov[c] = 1;
            end
         end
         if (wr_en && wr_data[3]) m_rto = 0;
         if (run) begin
            if (m_cnt == int'(reload)) begin m_cnt = 1; m_rto = 1; end
            else m_cnt = (m_cnt + 1) % 65536;
         end
         if (wr_en && wr_data[7]) m_noise = 0;
         if (nf_enable && nf_strobe) m_noise = 1;
      end
   end

   function automatic logic [7:0] model_byte();
      return {m_noise, 1'b0, m_ov[1], m_ov[0], m_rto, 1'b0, m_ef[1], m_ef[0]};
   endfunction

   task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check8("MODEL rd_data", rd_data, model_byte());
         checks++;
         if (cnt_value !== 16'(m_cnt)) begin
            failures++;
            $display("FAIL R7 cnt actual=0x%04h expected=0x%04h", cnt_value, m_cnt);
         end
         checks++;
         if (irq !== (irq_en & (m_ef[0] | m_ef[1] | m_rto))) begin
            failures++;
            $display("FAIL R9 irq actual=%0b expected=%0b", irq,
                     irq_en & (m_ef[0] | m_ef[1] | m_rto));
         end
      end
   end

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
      #1;
      ch_evt = 2'b00; wr_en = 1'b0; wr_data = 8'h00; nf_strobe = 1'b0;
   endtask

   task automatic wr(logic [7:0] d);
      wr_en = 1'b1; wr_data = d;
      cyc();
   endtask

   task automatic finish_run();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check8("R1 reset status", rd_data, 8'h00);
      check8("R1 reset cnt lo", cnt_value[7:0], 8'h01);
      check8("R1 reset irq", {7'd0, irq}, 8'h00);

      ch_evt = 2'b01; cyc();
      check8("R3 ch0 event, irq_en low", rd_data, 8'h01);
      check8("R9 irq gated off", {7'd0, irq}, 8'h00);
      ch_evt = 2'b01; cyc();
      check8("R5 back-to-back overrun ch0", rd_data, 8'h11);
      ch_evt = 2'b10; cyc();
      check8("R3 ch1 event", rd_data, 8'h13);
      wr(8'h00);
      check8("R4 write zero no change", rd_data, 8'h13);
      wr(8'h74);
      check8("R2 reserved/overrun writes ignored", rd_data, 8'h13);
      wr(8'h01);
      check8("R4 clear ch0 clears its overrun", rd_data, 8'h02);
      ch_evt = 2'b10; wr_en = 1'b1; wr_data = 8'h02; cyc();
      check8("R6 set wins with overrun", rd_data, 8'h22);
      wr(8'h02);
      check8("R4 clear ch1", rd_data, 8'h00);
      ch_evt = 2'b01; wr_en = 1'b1; wr_data = 8'h01; cyc();
      check8("R6 set wins no prior pending", rd_data, 8'h01);
      irq_en = 1'b1; #1;
      check8("R9 irq on enable", {7'd0, irq}, 8'h01);
      wr(8'h01);
      check8("R9 irq drops after clear", {7'd0, irq}, 8'h00);

      nf_enable = 1'b0;
      repeat (3) begin nf_strobe = 1'b1; cyc(); end
      check8("R8 strobe ignored when disabled", rd_data, 8'h00);
      nf_enable = 1'b1; nf_strobe = 1'b1; cyc();
      check8("R8 noise flag set", rd_data, 8'h80);
      wr(8'h80);
      check8("R8 noise flag cleared", rd_data, 8'h00);

      reload = 16'd5; run = 1'b1;
      repeat (4) cyc();
      check8("R7 counter reached reload", cnt_value[7:0], 8'h05);
      check8("R7 no timeout yet", rd_data, 8'h00);
      cyc();
      check8("R7 wrap to 0x0001", cnt_value[7:0], 8'h01);
      check8("R7 timeout flag", rd_data, 8'h08);
      run = 1'b0;
      repeat (2) cyc();
      check8("R9 irq held", {7'd0, irq}, 8'h01);
      wr(8'h08);
      check8("R7 timeout cleared", rd_data, 8'h00);

      reload = 16'd2; run = 1'b1;
      for (int i = 0; i < 300; i++) begin
         ch_evt    = 2'($urandom_range(0, 3));
         nf_enable = 1'($urandom_range(0, 1));
         nf_strobe = 1'($urandom_range(0, 1));
         irq_en    = 1'($urandom_range(0, 1));
         wr_en     = ($urandom_range(0, 3) == 0);
         wr_data   = 8'($urandom_range(0, 255));
         if (i % 50 == 0) reload = 16'($urandom_range(1, 7));
         cyc();
      end
      run = 1'b0;
      cyc();
      finish_run();
   end
endmodule